// File: doc/BRIEF.md
# Dual-Mode Serial Stream Controller

This block holds a 128 x 8 configuration store and decides who owns the shared serial data pin. After reset it runs on its own: each rising edge of a slow stream clock advances a bit sequencer. Nine warm-up pulses produce nothing. Then the store is sent byte by byte, starting at address 00h. Each byte goes out most significant bit first and is followed by one idle slot in which the pin is released.

A falling edge on the two-wire bus clock stops the stream and puts the block into a waiting mode. In that mode a separate bus engine looks for a valid control byte. If the engine reports one, the block gives up the stream for good: it enters bidirectional mode, where the stream clock has no effect, and stays there until reset. If no control byte arrives and the bus clock stays high for 128 stream pulses in a row, the block goes back to streaming from the start. Both external clocks are oversampled by the fast system clock. The store is written through a plain byte port that the bus engine uses.

Top module: `dual_mode_stream_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `mode_o` is 0 (stream) and `sda_oe` is 0. Mode codes: 0 = stream, 1 = waiting, 2 = bidirectional.
- R2: On entering stream mode, the first nine stream-clock rising edges leave `sda_oe` low. The tenth rising edge drives bit 7 of address 00h.
- R3: A byte takes nine stream-clock rising edges. The first eight each drive one data bit, from bit 7 down to bit 0, with `sda_oe` high. On the ninth, `sda_oe` is low.
- R4: The byte address goes up by one after each idle slot, and wraps from 7Fh back to 00h.
- R5: In stream mode, a falling edge of `bus_clk` sets `mode_o` to 1 and releases `sda_oe`.
- R6: A `ctrl_ok` pulse in waiting mode sets `mode_o` to 2. Mode 2 is kept until reset.
- R7: In waiting mode, 128 consecutive stream-clock rising edges seen with `bus_clk` high return `mode_o` to 0. Streaming then restarts with the warm-up pulses at address 00h.
- R8: In waiting mode, any edge of `bus_clk`, or a low level on it, clears the idle pulse count, so a return needs 128 fresh pulses.
- R9: In mode 2, stream-clock edges never drive the pin: `sda_oe` stays 0 and `mode_o` stays 2.
- R10: A `ctrl_ok` pulse in stream mode does nothing. The mode stays 0 and the bit sequence goes on.
- R11: A byte written through `wr_en`/`wr_addr`/`wr_data` is the byte later streamed for that address, and it survives a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both external clocks are oversampled by it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strm_clk | input | 1 | Stream clock for the autonomous transmit mode |
| bus_clk | input | 1 | Two-wire bus clock line (idle high) |
| ctrl_ok | input | 1 | One-cycle pulse from the bus engine: valid control byte seen |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 7 | Store write address |
| wr_data | input | 8 | Store write data |
| sda_oe | output | 1 | Drive enable for the shared data pin |
| sda_out | output | 1 | Bit value for the shared data pin |
| mode_o | output | 2 | Current mode: 0 stream, 1 waiting, 2 bidirectional |

## Verification
The assertions assume that `ctrl_ok` is a single-cycle pulse. They also assume that both external clocks are far slower than `clk`, each level being held long enough to pass through the synchronizer and edge register, so that every external edge gives exactly one internal pulse. The stimulus holds every `strm_clk` and `bus_clk` level for six system cycles. It never moves two external inputs in the same cycle, and it drives everything on the falling edge of `clk`.

// File: rtl/dmsc_pkg.sv
package dmsc_pkg;
  typedef enum logic [1:0] {
    MODE_STREAM = 2'd0,
    MODE_TRANS  = 2'd1,
    MODE_BIDIR  = 2'd2
  } mode_e;
endpackage

// File: rtl/dmsc_edge_sync.sv
// Oversampling synchronizer; exposes the newest settled level and the one before it.
module dmsc_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-1:0], din};
  end

  assign lvl  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];
endmodule

// File: rtl/dmsc_mode_fsm.sv
module dmsc_mode_fsm
  import dmsc_pkg::*;
#(
  parameter int IDLE_LIMIT = 128,
  localparam int CNT_W     = $clog2(IDLE_LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strm_rise,
  input  logic             bus_lvl,
  input  logic             bus_fall,
  input  logic             bus_act,
  input  logic             ctrl_ok,
  output mode_e            mode,
  output logic [CNT_W-1:0] idle_cnt
);
  mode_e            mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    unique case (mode_q)
      MODE_STREAM: begin
        cnt_d = '0;
        if (bus_fall) mode_d = MODE_TRANS;
      end
      MODE_TRANS: begin
        if (ctrl_ok) begin
          mode_d = MODE_BIDIR;
          cnt_d  = '0;
        end else if (bus_act || !bus_lvl) begin
          cnt_d = '0;
        end else if (strm_rise) begin
          if (cnt_q == CNT_W'(IDLE_LIMIT - 1)) begin
            mode_d = MODE_STREAM;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      MODE_BIDIR: cnt_d = '0;
      default: begin
        mode_d = MODE_STREAM;
        cnt_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STREAM;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode     = mode_q;
  assign idle_cnt = cnt_q;
endmodule

// File: rtl/dmsc_stream_seq.sv
// Warm-up, bit-slot and address sequencing for transmit-only mode.
module dmsc_stream_seq #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int WARM_CLKS = 9,
  localparam int WARM_W   = $clog2(WARM_CLKS + 1),
  localparam int SLOT_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              strm_rise,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              oe,
  output logic              dout
);
  logic [WARM_W-1:0] warm_q, warm_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              oe_q, oe_d, dout_q, dout_d;
  logic [DATA_W-1:0] shifted;

  assign shifted = rd_data << slot_q;

  always_comb begin
    warm_d = warm_q;
    slot_d = slot_q;
    addr_d = addr_q;
    oe_d   = oe_q;
    dout_d = dout_q;
    if (!active) begin
      // Leaving stream mode rewinds everything for the next entry.
      warm_d = '0;
      slot_d = '0;
      addr_d = '0;
      oe_d   = 1'b0;
      dout_d = 1'b0;
    end else if (strm_rise) begin
      if (warm_q != WARM_W'(WARM_CLKS)) begin
        warm_d = warm_q + WARM_W'(1);
      end else if (slot_q == SLOT_W'(DATA_W)) begin
        oe_d   = 1'b0;
        dout_d = 1'b0;
        slot_d = '0;
        addr_d = addr_q + ADDR_W'(1);
      end else begin
        oe_d   = 1'b1;
        dout_d = shifted[DATA_W-1];
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      slot_q <= '0;
      addr_q <= '0;
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      warm_q <= warm_d;
      slot_q <= slot_d;
      addr_q <= addr_d;
      oe_q   <= oe_d;
      dout_q <= dout_d;
    end
  end

  assign rd_addr = addr_q;
  assign oe      = oe_q & active;
  assign dout    = dout_q;
endmodule

// File: rtl/dual_mode_stream_ctrl.sv
module dual_mode_stream_ctrl
  import dmsc_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int IDLE_LIMIT  = 128,
  parameter int WARM_CLKS   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strm_clk,
  input  logic              bus_clk,
  input  logic              ctrl_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              sda_out,
  output logic [1:0]        mode_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(IDLE_LIMIT);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic              strm_lvl, strm_prev, strm_rise;
  logic              bus_lvl, bus_prev, bus_fall, bus_act;
  mode_e             mode;
  logic [CNT_W-1:0]  idle_cnt;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] mem_q [DEPTH];

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  dmsc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_strm_sync (
    .clk(clk), .rst_n(rst_n_s), .din(strm_clk), .lvl(strm_lvl), .prev(strm_prev));
  // The bus line idles high, so its history starts high.
  dmsc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_n_s), .din(bus_clk), .lvl(bus_lvl), .prev(bus_prev));

  assign strm_rise = strm_lvl & ~strm_prev;
  assign bus_fall  = bus_prev & ~bus_lvl;
  assign bus_act   = bus_prev ^ bus_lvl;

  dmsc_mode_fsm #(.IDLE_LIMIT(IDLE_LIMIT)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .strm_rise(strm_rise), .bus_lvl(bus_lvl),
    .bus_fall(bus_fall), .bus_act(bus_act), .ctrl_ok(ctrl_ok),
    .mode(mode), .idle_cnt(idle_cnt));

  // Storage array: contents are kept across reset on purpose.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end
  assign rd_data = mem_q[rd_addr];

  dmsc_stream_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WARM_CLKS(WARM_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .active(mode == MODE_STREAM), .strm_rise(strm_rise),
    .rd_data(rd_data), .rd_addr(rd_addr), .oe(sda_oe), .dout(sda_out));

  assign mode_o = mode;
endmodule

// File: rtl/dmsc_checker.sv
module dmsc_checker
  import dmsc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             sda_oe,
  input logic             strm_rise,
  input logic             bus_fall,
  input logic             ctrl_ok,
  input logic [CNT_W-1:0] idle_cnt
);
  p_trans_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STREAM && bus_fall) |=> (mode == MODE_TRANS));

  p_ctrl_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TRANS && ctrl_ok) |=> (mode == MODE_BIDIR));

  p_bidir_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BIDIR) |=> (mode == MODE_BIDIR));

  p_ctrl_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STREAM) |=> (mode != MODE_BIDIR));

  p_pin_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_STREAM) |-> !sda_oe);

  p_drive_on_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(strm_rise));

  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TRANS && bus_fall && !ctrl_ok) |=> (idle_cnt == '0));
endmodule

bind dual_mode_stream_ctrl dmsc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .mode(mode_o), .sda_oe(sda_oe),
  .strm_rise(strm_rise), .bus_fall(bus_fall), .ctrl_ok(ctrl_ok), .idle_cnt(idle_cnt));

// File: tb/dual_mode_stream_ctrl_tb.sv
module dual_mode_stream_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n, strm_clk, bus_clk, ctrl_ok, wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic       sda_oe, sda_out;
  logic [1:0] mode_o;
  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dual_mode_stream_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .strm_clk(strm_clk), .bus_clk(bus_clk), .ctrl_ok(ctrl_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe), .sda_out(sda_out), .mode_o(mode_o));

  // Op codes: 0 stream pulse, 1 bus clock low, 2 bus clock high, 3 ctrl_ok pulse.
  localparam int NVEC = 10;
  localparam logic [3:0] VEC [NVEC] = '{
    {2'd1, 2'd1}, {2'd0, 2'd1}, {2'd2, 2'd1}, {2'd3, 2'd2}, {2'd0, 2'd2},
    {2'd0, 2'd2}, {2'd1, 2'd2}, {2'd2, 2'd2}, {2'd3, 2'd2}, {2'd0, 2'd2}};

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + 5);
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strm_pulse();
    strm_clk = 1'b1; wait_n(6);
    strm_clk = 1'b0; wait_n(6);
  endtask

  task automatic ctrl_pulse();
    ctrl_ok = 1'b1; wait_n(1);
    ctrl_ok = 1'b0; wait_n(3);
  endtask

  task automatic warmup_then_first(string req);
    for (int i = 0; i < 9; i++) begin
      strm_pulse();
      check({req, " warm-up oe"}, sda_oe, 0);
    end
    strm_pulse();
    check({req, " first bit"}, {sda_oe, sda_out}, {1'b1, pat(0)[7]});
  endtask

  initial begin
    rst_n = 1'b0; strm_clk = 1'b0; bus_clk = 1'b1; ctrl_ok = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    wait_n(3);
    check("R1 reset mode", mode_o, 0);
    check("R1 reset oe", sda_oe, 0);
    rst_n = 1'b1;
    wait_n(4);
    check("R1 after release", {mode_o, sda_oe}, 0);

    // R11: fill the store
    for (int a = 0; a < 128; a++) begin
      wr_en = 1'b1; wr_addr = 7'(a); wr_data = pat(a);
      wait_n(1);
    end
    wr_en = 1'b0;

    // R2 warm-up, then R3/R4/R11 on full pass plus wrap
    warmup_then_first("R2");
    for (int b = 1; b < 8; b++) begin
      strm_pulse();
      check("R3 byte 0 bit", {sda_oe, sda_out}, {1'b1, pat(0)[7-b]});
    end
    strm_pulse();
    check("R3 null slot", sda_oe, 0);
    for (int n = 1; n < 130; n++) begin
      for (int b = 0; b < 8; b++) begin
        strm_pulse();
        check(n >= 128 ? "R4 wrap bit" : "R11 streamed bit",
              {sda_oe, sda_out}, {1'b1, pat(n % 128)[7-b]});
      end
      strm_pulse();
      check("R3 null slot", sda_oe, 0);
    end

    // R10: ctrl_ok while streaming
    ctrl_pulse();
    check("R10 mode kept", mode_o, 0);
    strm_pulse();
    check("R10 sequence continues", {sda_oe, sda_out}, {1'b1, pat(2)[7]});

    // R5: bus falling edge
    bus_clk = 1'b0; wait_n(6);
    check("R5 mode", mode_o, 1);
    check("R5 pin released", sda_oe, 0);

    // R8 / R7: idle timeout
    bus_clk = 1'b1; wait_n(6);
    for (int i = 0; i < 127; i++) strm_pulse();
    check("R7 127 pulses stay", mode_o, 1);
    bus_clk = 1'b0; wait_n(6);
    bus_clk = 1'b1; wait_n(6);
    for (int i = 0; i < 127; i++) strm_pulse();
    check("R8 count cleared", mode_o, 1);
    strm_pulse();
    check("R7 timeout return", mode_o, 0);
    warmup_then_first("R7");

    // Table: R5 waiting mode, R6 / R9 bidirectional
    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v][3:2])
        2'd0: strm_pulse();
        2'd1: begin bus_clk = 1'b0; wait_n(6); end
        2'd2: begin bus_clk = 1'b1; wait_n(6); end
        default: ctrl_pulse();
      endcase
      check(VEC[v][1:0] == 2'd2 ? "R9 table step" : "R5 table step",
            {sda_oe, mode_o}, {1'b0, VEC[v][1:0]});
    end

    // R1 / R11: reset leaves bidirectional mode, store kept
    rst_n = 1'b0; wait_n(2);
    check("R1 second reset", {mode_o, sda_oe}, 0);
    rst_n = 1'b1; wait_n(4);
    warmup_then_first("R11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule